// File: doc/BRIEF.md
# Flash Reset and Ready Sequencer

This block is the device-side controller for the reset pin, the ready/busy line and output gating of a parallel NOR-style flash. It takes an active-low reset pin from outside, synchronizes it, and filters out pulses that are too short. When a low pulse qualifies, it aborts any embedded program or erase operation that is running. It then returns reads to array mode and drives the ready line through a recovery period. The length of that period depends on whether an operation was running when the reset qualified.

While the synchronized pin is low, the data outputs are undriven and all commands are refused. After the pin goes high again, access stays blocked for a programmable settling time. An address-stability timer puts the output stage into a low-power sleep state in which the last data word stays latched.

The array and the embedded algorithms are modelled by a single busy flag. A command strobe starts an operation and a done strobe ends it.

Top module: `flash_rst_seq`

## Requirements
- R1: The reset pin passes through a two-stage synchronizer. A low level counts as a reset only once the synchronized pin has been sampled low on T_RP consecutive clock edges.
- R2: While the synchronized pin is low, `cmd_accept` is 0 and `dq_oe` is 0 from the next edge onward.
- R3: A qualified reset clears `op_busy` and sets `array_mode` to 1 on the same edge.
- R4: If `op_busy` is 1 when the reset qualifies, `ready` is 0 for exactly T_READY_EMB cycles starting at that edge, and then returns to 1.
- R5: If no operation is running when the reset qualifies, `ready` stays 1. Access stays refused until T_READY_IDLE cycles after the qualifying edge.
- R6: After the synchronized pin returns high, commands and output drive stay refused for T_RH edges.
- R7: `dq_oe` is registered. It becomes 1 one edge after `oe_n` is low while access is allowed, and it becomes 0 one edge after `oe_n` goes high.
- R8: After the address has been stable for T_SLEEP edges, `sleep` is 1 and `dq_out` holds its value even if `arr_data` changes. An address change clears `sleep` and loads `dq_out` on that same edge.
- R9: `aborted` becomes 1 when a reset qualifies during an operation. The next accepted command clears it.
- R10: A low pulse shorter than T_RP edges leaves `op_busy`, `aborted` and `array_mode` unchanged.
- R11: An accepted command with `cmd_is_op`=1 sets `op_busy` (so `ready` is 0) and sets `array_mode` to 0. `op_done` clears `op_busy` and sets `array_mode` back to 1. A command is accepted only while no operation is busy.
- R12: The synchronous reset `rst` gives the following state: `ready`=1, `op_busy`=0, `aborted`=0, `array_mode`=1, `dq_oe`=0, `sleep`=0, `dq_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| rst_pin_n | input | 1 | Asynchronous active-low hardware reset pin |
| oe_n | input | 1 | Active-low output enable |
| addr | input | AW | Read address |
| arr_data | input | DW | Data word from the array for `addr` |
| cmd_valid | input | 1 | Command strobe |
| cmd_is_op | input | 1 | Command starts a program/erase operation |
| op_done | input | 1 | Embedded operation finished |
| ready | output | 1 | 1 = ready, 0 = busy |
| cmd_accept | output | 1 | Command taken this cycle |
| op_busy | output | 1 | Embedded operation in progress |
| aborted | output | 1 | Sticky: an operation was cut by reset |
| array_mode | output | 1 | 1 = array read mode, 0 = status mode |
| dq_oe | output | 1 | Data output drive (0 = high impedance) |
| dq_out | output | DW | Latched output data |
| sleep | output | 1 | Low-power idle active |

## Verification
Latencies differ by output:
- A pin edge first reaches the control logic two edges later.
- `dq_oe`, `dq_out`, `sleep` and all flags follow one edge after their cause.
- `cmd_accept` is combinational on the current inputs.

The bench model applies every input at the same edge the design samples it. It then compares all outputs three nanoseconds later, well before the stimulus changes at the falling edge. The directed checks count cycles from observable events, for example the first cycle with `op_busy` low, and never from assumed absolute times.

// File: rtl/flrs_pkg.sv
package flrs_pkg;
  typedef enum logic {
    MD_STATUS = 1'b0,
    MD_ARRAY  = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/flrs_rst_qual.sv
module flrs_rst_qual #(
  parameter int SYNC_STAGES = 2,
  parameter int T_RP        = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n_i,
  output logic sync_n_o,
  output logic qual_o
);
  localparam int LW = $clog2(T_RP + 1);
  localparam logic [LW-1:0] LOW_MAX  = LW'(T_RP);
  localparam logic [LW-1:0] LOW_LAST = LW'(T_RP - 1);

  logic [SYNC_STAGES-1:0] chain;
  logic [LW-1:0]          low_cnt;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b1;
        else     chain[i] <= pin_n_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b1;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  assign sync_n_o = chain[SYNC_STAGES-1];
  assign qual_o   = !sync_n_o && (low_cnt == LOW_LAST);

  always_ff @(posedge clk) begin
    if (rst || sync_n_o)        low_cnt <= '0;
    else if (low_cnt < LOW_MAX) low_cnt <= low_cnt + 1'b1;
  end
endmodule

// File: rtl/flrs_ctl.sv
module flrs_ctl
  import flrs_pkg::*;
#(
  parameter int T_READY_EMB  = 20,
  parameter int T_READY_IDLE = 6,
  parameter int T_RH         = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_n_i,
  input  logic qual_i,
  input  logic oe_n,
  input  logic cmd_valid,
  input  logic cmd_is_op,
  input  logic op_done,
  output logic ready,
  output logic cmd_accept,
  output logic op_busy,
  output logic aborted,
  output logic array_mode,
  output logic dq_oe
);
  localparam int RW = $clog2(T_READY_EMB + 1);
  localparam int HW = $clog2(T_RH + 1);
  localparam logic [RW-1:0] REC_EMB  = RW'(T_READY_EMB);
  localparam logic [RW-1:0] REC_IDLE = RW'(T_READY_IDLE);
  localparam logic [HW-1:0] RH_LOAD  = HW'(T_RH);

  logic [RW-1:0] rec_cnt;
  logic [HW-1:0] rh_cnt;
  logic          busy_q, emb_rec_q, abort_q, oe_q;
  rd_mode_e      mode_q;
  logic          access_ok;

  assign access_ok  = sync_n_i && (rh_cnt == '0) && (rec_cnt == '0);
  assign cmd_accept = cmd_valid && access_ok && !busy_q;

  always_ff @(posedge clk) begin
    if (rst)            rh_cnt <= '0;
    else if (!sync_n_i) rh_cnt <= RH_LOAD;
    else if (rh_cnt != '0) rh_cnt <= rh_cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rec_cnt   <= '0;
      emb_rec_q <= 1'b0;
      busy_q    <= 1'b0;
      abort_q   <= 1'b0;
      mode_q    <= MD_ARRAY;
    end else if (qual_i) begin
      rec_cnt   <= busy_q ? REC_EMB : REC_IDLE;
      emb_rec_q <= busy_q;
      busy_q    <= 1'b0;
      abort_q   <= abort_q | busy_q;
      mode_q    <= MD_ARRAY;
    end else begin
      if (rec_cnt != '0) begin
        rec_cnt <= rec_cnt - 1'b1;
        if (rec_cnt == RW'(1)) emb_rec_q <= 1'b0;
      end
      if (cmd_accept) abort_q <= 1'b0;
      if (op_done) begin
        busy_q <= 1'b0;
        mode_q <= MD_ARRAY;
      end else if (cmd_accept && cmd_is_op) begin
        busy_q <= 1'b1;
        mode_q <= MD_STATUS;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) oe_q <= 1'b0;
    else     oe_q <= access_ok && !oe_n;
  end

  assign ready      = !(busy_q || emb_rec_q);
  assign op_busy    = busy_q;
  assign aborted    = abort_q;
  assign array_mode = (mode_q == MD_ARRAY);
  assign dq_oe      = oe_q;
endmodule

// File: rtl/flrs_sleep.sv
module flrs_sleep #(
  parameter int AW      = 8,
  parameter int DW      = 8,
  parameter int T_SLEEP = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] arr_data,
  output logic [DW-1:0] dq_out,
  output logic          sleep
);
  localparam int SW = $clog2(T_SLEEP + 1);
  localparam logic [SW-1:0] STAB_MAX = SW'(T_SLEEP);

  logic [AW-1:0] addr_q;
  logic [SW-1:0] stab_cnt;
  logic [DW-1:0] data_q;
  logic          addr_chg, awake;

  assign addr_chg = (addr != addr_q);
  assign awake    = addr_chg || (stab_cnt != STAB_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      stab_cnt <= '0;
      data_q   <= '0;
    end else begin
      addr_q <= addr;
      if (addr_chg)                  stab_cnt <= '0;
      else if (stab_cnt != STAB_MAX) stab_cnt <= stab_cnt + 1'b1;
      if (awake) data_q <= arr_data;
    end
  end

  assign dq_out = data_q;
  assign sleep  = (stab_cnt == STAB_MAX);
endmodule

// File: rtl/flash_rst_seq.sv
module flash_rst_seq #(
  parameter int AW           = 8,
  parameter int DW           = 8,
  parameter int SYNC_STAGES  = 2,
  parameter int T_RP         = 4,
  parameter int T_READY_EMB  = 20,
  parameter int T_READY_IDLE = 6,
  parameter int T_RH         = 3,
  parameter int T_SLEEP      = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rst_pin_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] arr_data,
  input  logic          cmd_valid,
  input  logic          cmd_is_op,
  input  logic          op_done,
  output logic          ready,
  output logic          cmd_accept,
  output logic          op_busy,
  output logic          aborted,
  output logic          array_mode,
  output logic          dq_oe,
  output logic [DW-1:0] dq_out,
  output logic          sleep
);
  logic sync_n, qual;

  flrs_rst_qual #(.SYNC_STAGES(SYNC_STAGES), .T_RP(T_RP)) u_qual (
    .clk(clk), .rst(rst), .pin_n_i(rst_pin_n), .sync_n_o(sync_n), .qual_o(qual)
  );

  flrs_ctl #(.T_READY_EMB(T_READY_EMB), .T_READY_IDLE(T_READY_IDLE), .T_RH(T_RH)) u_ctl (
    .clk(clk), .rst(rst), .sync_n_i(sync_n), .qual_i(qual), .oe_n(oe_n),
    .cmd_valid(cmd_valid), .cmd_is_op(cmd_is_op), .op_done(op_done),
    .ready(ready), .cmd_accept(cmd_accept), .op_busy(op_busy), .aborted(aborted),
    .array_mode(array_mode), .dq_oe(dq_oe)
  );

  flrs_sleep #(.AW(AW), .DW(DW), .T_SLEEP(T_SLEEP)) u_sleep (
    .clk(clk), .rst(rst), .addr(addr), .arr_data(arr_data), .dq_out(dq_out), .sleep(sleep)
  );
endmodule

// File: rtl/flrs_checker.sv
module flrs_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          pin_sync,
  input logic          qual,
  input logic          oe_n,
  input logic          op_done,
  input logic          cmd_accept,
  input logic          dq_oe,
  input logic          ready,
  input logic          op_busy,
  input logic          aborted,
  input logic          array_mode,
  input logic          sleep,
  input logic [DW-1:0] dq_out
);
  AST_RST_NO_CMD:   assert property (@(posedge clk) disable iff (rst) !pin_sync |-> !cmd_accept); // R2
  AST_RST_HIZ:      assert property (@(posedge clk) disable iff (rst) !pin_sync |=> !dq_oe); // R2
  AST_OE_HIZ:       assert property (@(posedge clk) disable iff (rst) oe_n |=> !dq_oe); // R7
  AST_QUAL_CLEAR:   assert property (@(posedge clk) disable iff (rst) qual |=> (!op_busy && array_mode)); // R3
  AST_EMB_BUSY:     assert property (@(posedge clk) disable iff (rst) (qual && op_busy) |=> !ready); // R4
  AST_IDLE_READY:   assert property (@(posedge clk) disable iff (rst) (qual && !op_busy) |=> ready); // R5
  AST_ABORT_SET:    assert property (@(posedge clk) disable iff (rst) (qual && op_busy) |=> aborted); // R9
  AST_SLEEP_HOLD:   assert property (@(posedge clk) disable iff (rst) (sleep && $past(sleep)) |-> $stable(dq_out)); // R8
  AST_DONE_CLEAR:   assert property (@(posedge clk) disable iff (rst) (op_done && !qual) |=> (!op_busy && array_mode)); // R11
endmodule

bind flash_rst_seq flrs_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .pin_sync(sync_n), .qual(qual), .oe_n(oe_n), .op_done(op_done),
  .cmd_accept(cmd_accept), .dq_oe(dq_oe), .ready(ready), .op_busy(op_busy),
  .aborted(aborted), .array_mode(array_mode), .sleep(sleep), .dq_out(dq_out)
);

// File: tb/flash_rst_seq_tb_top.sv
module flash_rst_seq_tb_top;
  localparam int AW = 8, DW = 8, T_RP = 4, T_EMB = 20, T_IDLE = 6, T_RH = 3, T_SLEEP = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rst_pin_n = 1'b1, oe_n = 1'b1, cmd_valid = 1'b0, cmd_is_op = 1'b0, op_done = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] salt = 8'h5A;
  logic [DW-1:0] arr_data;
  logic ready, cmd_accept, op_busy, aborted, array_mode, dq_oe, sleep;
  logic [DW-1:0] dq_out;

  int checks = 0, errors = 0;

  assign arr_data = addr ^ salt;
  always #5 clk = ~clk;

  flash_rst_seq #(.AW(AW), .DW(DW), .T_RP(T_RP), .T_READY_EMB(T_EMB),
                  .T_READY_IDLE(T_IDLE), .T_RH(T_RH), .T_SLEEP(T_SLEEP)) dut_i (
    .clk(clk), .rst(rst), .rst_pin_n(rst_pin_n), .oe_n(oe_n), .addr(addr), .arr_data(arr_data),
    .cmd_valid(cmd_valid), .cmd_is_op(cmd_is_op), .op_done(op_done), .ready(ready),
    .cmd_accept(cmd_accept), .op_busy(op_busy), .aborted(aborted), .array_mode(array_mode),
    .dq_oe(dq_oe), .dq_out(dq_out), .sleep(sleep)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: pin history queue, run lengths and timers as integers
  logic pin_hist[$] = '{1'b1, 1'b1};
  int low_run = 0, hold_left = 0, recover_left = 0, stable_run = 0;
  bit m_busy = 0, m_embwait = 0, m_abort = 0, m_array = 1, m_oe = 0;
  int last_addr = 0, m_dq = 0;

  always @(posedge clk) begin
    bit seen_n, can_access, took, fire;
    if (rst) begin
      pin_hist = '{1'b1, 1'b1};
      low_run = 0; hold_left = 0; recover_left = 0; stable_run = 0;
      m_busy = 0; m_embwait = 0; m_abort = 0; m_array = 1; m_oe = 0;
      last_addr = 0; m_dq = 0;
    end else begin
      seen_n     = pin_hist[0];
      can_access = seen_n && hold_left == 0 && recover_left == 0;
      took       = cmd_valid && can_access && !m_busy;
      fire       = !seen_n && (low_run + 1 == T_RP);
      if (fire) begin
        recover_left = m_busy ? T_EMB : T_IDLE;
        m_embwait = m_busy;
        if (m_busy) m_abort = 1;
        m_busy = 0; m_array = 1;
      end else begin
        if (recover_left > 0) begin
          recover_left--;
          if (recover_left == 0) m_embwait = 0;
        end
        if (took) m_abort = 0;
        if (op_done) begin m_busy = 0; m_array = 1; end
        else if (took && cmd_is_op) begin m_busy = 1; m_array = 0; end
      end
      low_run   = seen_n ? 0 : low_run + 1;
      hold_left = !seen_n ? T_RH : (hold_left > 0 ? hold_left - 1 : 0);
      m_oe      = can_access && !oe_n;
      if (int'(addr) != last_addr) begin stable_run = 0; m_dq = int'(arr_data); end
      else if (stable_run != T_SLEEP) begin stable_run++; m_dq = int'(arr_data); end
      last_addr = int'(addr);
      void'(pin_hist.pop_front());
      pin_hist.push_back(rst_pin_n);
    end
    #3;
    check("R4/R5", "ready", int'(ready), int'(!(m_busy || m_embwait)));
    check("R2/R6", "cmd_accept", int'(cmd_accept),
          int'(cmd_valid && pin_hist[0] && hold_left == 0 && recover_left == 0 && !m_busy));
    check("R11/R10", "op_busy", int'(op_busy), int'(m_busy));
    check("R9", "aborted", int'(aborted), int'(m_abort));
    check("R3", "array_mode", int'(array_mode), int'(m_array));
    check("R7", "dq_oe", int'(dq_oe), int'(m_oe));
    check("R8", "dq_out", int'(dq_out), m_dq);
    check("R8", "sleep", int'(sleep), int'(stable_run == T_SLEEP));
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue(input bit is_op);
    cmd_valid = 1'b1; cmd_is_op = is_op;
    tick(1);
    cmd_valid = 1'b0; cmd_is_op = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int lowcnt;
    tick(3);
    // R12: state after system reset
    check("R12", "ready", int'(ready), 1);
    check("R12", "op_busy", int'(op_busy), 0);
    check("R12", "aborted", int'(aborted), 0);
    check("R12", "array_mode", int'(array_mode), 1);
    check("R12", "dq_oe", int'(dq_oe), 0);
    check("R12", "sleep", int'(sleep), 0);
    rst = 1'b0;
    // R7: output drive follows oe_n one edge later
    oe_n = 1'b0; addr = 8'h11; tick(2);
    check("R7", "dq_oe on", int'(dq_oe), 1);
    oe_n = 1'b1; tick(1);
    check("R7", "dq_oe off", int'(dq_oe), 0);
    oe_n = 1'b0;
    // R8: sleep holds data, address change wakes
    addr = 8'h22; tick(T_SLEEP + 3);
    check("R8", "sleep entered", int'(sleep), 1);
    salt = 8'hC3; tick(2);
    check("R8", "data held", int'(dq_out), int'(8'h22 ^ 8'h5A));
    addr = 8'h23; tick(1);
    check("R8", "sleep left", int'(sleep), 0);
    check("R8", "new data", int'(dq_out), int'(8'h23 ^ 8'hC3));
    // R11: operation start and finish
    issue(1'b1); tick(1);
    check("R11", "busy", int'(op_busy), 1);
    check("R11", "status mode", int'(array_mode), 0);
    op_done = 1'b1; tick(1); op_done = 1'b0; tick(1);
    check("R11", "done", int'(op_busy), 0);
    // R10: short pulse while busy keeps state
    issue(1'b1); tick(2);
    rst_pin_n = 1'b0; tick(T_RP - 2); rst_pin_n = 1'b1; tick(T_RH + 4);
    check("R10", "busy kept", int'(op_busy), 1);
    check("R10", "status kept", int'(array_mode), 0);
    // R1/R4/R9: qualified reset during operation
    rst_pin_n = 1'b0;
    while (op_busy) tick(1);
    lowcnt = 0;
    while (!ready && lowcnt < 100) begin lowcnt++; tick(1); end
    check("R4", "ready low cycles", lowcnt, T_EMB);
    check("R9", "aborted set", int'(aborted), 1);
    check("R3", "array mode", int'(array_mode), 1);
    cmd_valid = 1'b1;
    check("R2", "cmd blocked while low", int'(cmd_accept), 0);
    rst_pin_n = 1'b1; tick(3);
    check("R6", "cmd blocked in settle", int'(cmd_accept), 0);
    tick(T_RH); 
    check("R6", "cmd after settle", int'(cmd_accept), 1);
    tick(1); cmd_valid = 1'b0; tick(1);
    check("R9", "aborted cleared", int'(aborted), 0);
    // R5: idle reset keeps ready high
    rst_pin_n = 1'b0; tick(T_RP + 8);
    check("R5", "ready idle", int'(ready), 1);
    check("R2", "hiz low", int'(dq_oe), 0);
    rst_pin_n = 1'b1; tick(T_RH + 6);
    check("R5", "aborted idle", int'(aborted), 0);
    check("R7", "drive back", int'(dq_oe), 1);
    tick(5);
    summary();
  end
endmodule